// File: doc/BRIEF.md
# Program-Mode Access Controller

This block governs access to a small array of 12-bit flash words while the device is in program/verify mode. A command port accepts five operations: enter mode, increment address, load word, read word and bulk erase. An internal address counter walks the user program region and then continues into the configuration region. Each access is sent to one of four stores: the user array, the user ID words, the backup oscillator calibration word or the configuration word. Locations that are reserved or not implemented are fenced off.

The configuration word sits at the top address. It can be reached only between mode entry and the first increment. Code protection hides the contents of the user array from reads, but the ID words stay readable. A bulk erase clears the user array, the ID words and the configuration word. It also clears the calibration backup only if the counter had already moved into the configuration region when the erase was issued. The storage is held in registers, so the block can stand in for the flash array in a model.

Top module: `pgmAccessCtl`

## Requirements
- R1: Command codes on `cmdCode` are 0 enter, 1 increment, 2 load, 3 read and 4 bulk erase. After reset, and after every accepted enter, `addrOut` is 0 and configuration-word access is armed. After reset `cmdReady` is high.
- R2: An increment while access is not armed adds one to the counter. From the last user word (USER_WORDS-1, 0x1FF by default) it moves to USER_WORDS (0x200), and from 2*USER_WORDS-1 (0x3FF) it wraps to 0.
- R3: While armed, load and read reach the configuration word whatever the counter shows. The first increment after entry only disarms and leaves the counter unchanged. After that the top address reads 12'hFFF and ignores loads.
- R4: The four ID words at USER_WORDS..USER_WORDS+3 can be loaded and read back, and they read their true contents while code protection is on.
- R5: Addresses USER_WORDS+5 through 2*USER_WORDS-2 ignore loads and read 12'hFFF.
- R6: While `protectEn` is high, reads of the user region return 12'h000. The configuration word still reads its true value.
- R7: A bulk erase issued while the counter is in the user region sets the user words, the ID words and the configuration word to 12'hFFF, and keeps the calibration backup at USER_WORDS+4.
- R8: A bulk erase issued while the counter is in the configuration region also sets the calibration backup to 12'hFFF.
- R9: Each accepted command other than erase drives `cmdReady` low for exactly one cycle. An accepted erase holds it low for ERASE_CYCLES cycles (16 by default), and the erase takes effect by the time `cmdReady` rises again. Read data appears on `rdData` in the cycle after acceptance.
- R10: The last user word (the reset vector holding the calibration literal) can be loaded and read on its own. The calibration backup resets to BACKUP_INIT and can be rewritten by a load.
- R11: A command presented while `cmdReady` is low is not accepted and has no effect on the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present |
| cmdCode | input | 3 | Command code (see R1) |
| cmdData | input | DATA_W | Word written by a load |
| protectEn | input | 1 | Code protection active |
| cmdReady | output | 1 | Command can be accepted this cycle |
| rdData | output | DATA_W | Word returned by the last read |
| addrOut | output | $clog2(USER_WORDS)+1 | Current address counter |

## Verification
The bench builds the block with USER_WORDS=16, ID_WORDS=4, ERASE_CYCLES=16 and BACKUP_INIT=12'hC34. With this small user region, the crossing from user space into configuration space, every reserved and unimplemented slot, and the full wrap back to address 0 can all be reached in a few dozen increments. The erase window keeps its default length, so the 16-cycle busy period is checked exactly as specified.

// File: rtl/pgmPkg.sv
`timescale 1ns/1ps
package pgmPkg;

  typedef enum logic [2:0] {
    CMD_ENTER = 3'd0,
    CMD_INCR  = 3'd1,
    CMD_LOAD  = 3'd2,
    CMD_READ  = 3'd3,
    CMD_ERASE = 3'd4
  } cmdE;

  typedef enum logic [2:0] {
    TGT_USER,
    TGT_ID,
    TGT_CAL,
    TGT_CFG,
    TGT_NONE
  } tgtE;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;
    logic rdEn;
    logic eraseNow;
    logic eraseCal;
    tgtE  target;
  } strobeT;

endpackage

// File: rtl/pgmCtrl.sv
`timescale 1ns/1ps
module pgmCtrl
  import pgmPkg::*;
#(
  parameter int USER_WORDS   = 512,
  parameter int ID_WORDS     = 4,
  parameter int ERASE_CYCLES = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cmdValid,
  input  logic [2:0]                    cmdCode,
  output logic                          cmdReady,
  output logic [$clog2(USER_WORDS):0]   addr,
  output logic                          cfgArmed,
  output strobeT                        strb
);

  localparam int AW = $clog2(USER_WORDS) + 1;
  localparam int CW = $clog2(ERASE_CYCLES + 1);

  logic [CW-1:0]   busyCnt;
  logic            erasing;
  logic            calDoom;
  logic            accept;
  logic            inUser;
  logic [AW-2:0]   cfgOff;
  cmdE             cmd;
  tgtE             target;

  assign cmd      = cmdE'(cmdCode);
  assign cmdReady = (busyCnt == '0);
  assign accept   = cmdValid && cmdReady;
  assign inUser   = !addr[AW-1];
  assign cfgOff   = addr[AW-2:0];

  // busy window and erase bookkeeping
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyCnt <= '0;
      erasing <= 1'b0;
      calDoom <= 1'b0;
    end else if (accept) begin
      busyCnt <= (cmd == CMD_ERASE) ? CW'(ERASE_CYCLES) : CW'(1);
      erasing <= (cmd == CMD_ERASE);
      if (cmd == CMD_ERASE) calDoom <= !inUser;
    end else if (busyCnt != '0) begin
      busyCnt <= busyCnt - CW'(1);
      if (busyCnt == CW'(1)) erasing <= 1'b0;
    end
  end

  // address counter and config-word arming
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addr     <= '0;
      cfgArmed <= 1'b1;
    end else if (accept) begin
      if (cmd == CMD_ENTER) begin
        addr     <= '0;
        cfgArmed <= 1'b1;
      end else if (cmd == CMD_INCR) begin
        if (cfgArmed) cfgArmed <= 1'b0;
        else          addr     <= addr + AW'(1);
      end
    end
  end

  // location decode
  always_comb begin
    if (cfgArmed)                         target = TGT_CFG;
    else if (inUser)                      target = TGT_USER;
    else if (cfgOff < (AW-1)'(ID_WORDS))  target = TGT_ID;
    else if (cfgOff == (AW-1)'(ID_WORDS)) target = TGT_CAL;
    else                                  target = TGT_NONE;
  end

  always_comb begin
    strb.wrEn     = accept && (cmd == CMD_LOAD);
    strb.rdEn     = accept && (cmd == CMD_READ);
    strb.eraseNow = erasing && (busyCnt == CW'(1));
    strb.eraseCal = calDoom;
    strb.target   = target;
  end

endmodule

// File: rtl/pgmStore.sv
`timescale 1ns/1ps
module pgmStore
  import pgmPkg::*;
#(
  parameter int              USER_WORDS  = 512,
  parameter int              ID_WORDS    = 4,
  parameter int              DATA_W      = 12,
  parameter logic [DATA_W-1:0] BACKUP_INIT = 12'hC34
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  strobeT                            strb,
  input  logic [$clog2(USER_WORDS)-1:0]     userIdx,
  input  logic [((ID_WORDS > 1) ? $clog2(ID_WORDS) : 1)-1:0] idIdx,
  input  logic [DATA_W-1:0]                 wrData,
  input  logic                              protectEn,
  output logic [DATA_W-1:0]                 rdData
);

  logic [DATA_W-1:0] userMem [USER_WORDS];
  logic [DATA_W-1:0] idMem   [ID_WORDS];
  logic [DATA_W-1:0] calWord;
  logic [DATA_W-1:0] cfgWord;

  always_ff @(posedge clk) begin
    if (!rstN || strb.eraseNow) begin
      for (int i = 0; i < USER_WORDS; i++) userMem[i] <= '1;
    end else if (strb.wrEn && strb.target == TGT_USER) begin
      userMem[userIdx] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.eraseNow) begin
      for (int i = 0; i < ID_WORDS; i++) idMem[i] <= '1;
    end else if (strb.wrEn && strb.target == TGT_ID) begin
      idMem[idIdx] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                    calWord <= BACKUP_INIT;
    else if (strb.eraseNow && strb.eraseCal)      calWord <= '1;
    else if (strb.wrEn && strb.target == TGT_CAL) calWord <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.eraseNow)                   cfgWord <= '1;
    else if (strb.wrEn && strb.target == TGT_CFG) cfgWord <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strb.rdEn) begin
      case (strb.target)
        TGT_USER: rdData <= protectEn ? '0 : userMem[userIdx];
        TGT_ID:   rdData <= idMem[idIdx];
        TGT_CAL:  rdData <= calWord;
        TGT_CFG:  rdData <= cfgWord;
        default:  rdData <= '1;
      endcase
    end
  end

endmodule

// File: rtl/pgmAccessCtl.sv
`timescale 1ns/1ps
module pgmAccessCtl
  import pgmPkg::*;
#(
  parameter int                USER_WORDS   = 512,
  parameter int                ID_WORDS     = 4,
  parameter int                ERASE_CYCLES = 16,
  parameter int                DATA_W       = 12,
  parameter logic [DATA_W-1:0] BACKUP_INIT  = 12'hC34
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cmdValid,
  input  logic [2:0]                  cmdCode,
  input  logic [DATA_W-1:0]           cmdData,
  input  logic                        protectEn,
  output logic                        cmdReady,
  output logic [DATA_W-1:0]           rdData,
  output logic [$clog2(USER_WORDS):0] addrOut
);

  localparam int AW  = $clog2(USER_WORDS) + 1;
  localparam int IDW = (ID_WORDS > 1) ? $clog2(ID_WORDS) : 1;

  strobeT        strb;
  logic [AW-1:0] addr;
  logic          cfgArmed;

  assign addrOut = addr;

  pgmCtrl #(
    .USER_WORDS  (USER_WORDS),
    .ID_WORDS    (ID_WORDS),
    .ERASE_CYCLES(ERASE_CYCLES)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .cmdValid(cmdValid),
    .cmdCode (cmdCode),
    .cmdReady(cmdReady),
    .addr    (addr),
    .cfgArmed(cfgArmed),
    .strb    (strb)
  );

  pgmStore #(
    .USER_WORDS (USER_WORDS),
    .ID_WORDS   (ID_WORDS),
    .DATA_W     (DATA_W),
    .BACKUP_INIT(BACKUP_INIT)
  ) uStore (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .userIdx  (addr[AW-2:0]),
    .idIdx    (addr[IDW-1:0]),
    .wrData   (cmdData),
    .protectEn(protectEn),
    .rdData   (rdData)
  );

endmodule

// File: rtl/pgmAccessCtl_chk.sv
`timescale 1ns/1ps
module pgmAccessCtl_chk #(
  parameter int USER_WORDS   = 512,
  parameter int ERASE_CYCLES = 16,
  parameter int DATA_W       = 12
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        cmdValid,
  input logic [2:0]                  cmdCode,
  input logic                        cmdReady,
  input logic                        protectEn,
  input logic [DATA_W-1:0]           rdData,
  input logic [$clog2(USER_WORDS):0] addrOut,
  input logic                        cfgArmed
);

  localparam int AW = $clog2(USER_WORDS) + 1;
  localparam int CW = $clog2(ERASE_CYCLES + 1);

  logic          acc;
  logic [CW-1:0] eraseLeft;

  assign acc = cmdValid && cmdReady;

  always_ff @(posedge clk) begin
    if (!rstN)                          eraseLeft <= '0;
    else if (acc && cmdCode == 3'd4)    eraseLeft <= CW'(ERASE_CYCLES);
    else if (eraseLeft != '0)           eraseLeft <= eraseLeft - CW'(1);
  end

  p_enter_r1: assert property (@(posedge clk) disable iff (!rstN)
    (acc && cmdCode == 3'd0) |=> (addrOut == '0 && cfgArmed));

  p_cross_r2: assert property (@(posedge clk) disable iff (!rstN)
    (acc && cmdCode == 3'd1 && !cfgArmed && addrOut == AW'(USER_WORDS - 1))
    |=> (addrOut == AW'(USER_WORDS)));

  p_wrap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (acc && cmdCode == 3'd1 && !cfgArmed && addrOut == AW'(2*USER_WORDS - 1))
    |=> (addrOut == '0));

  p_disarm_r3: assert property (@(posedge clk) disable iff (!rstN)
    (acc && cmdCode == 3'd1 && cfgArmed) |=> (!cfgArmed && $stable(addrOut)));

  p_protect_r6: assert property (@(posedge clk) disable iff (!rstN)
    (acc && cmdCode == 3'd3 && protectEn && !cfgArmed && !addrOut[AW-1])
    |=> (rdData == '0));

  p_ready_drop_r9: assert property (@(posedge clk) disable iff (!rstN)
    acc |=> !cmdReady);

  p_erase_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (eraseLeft != '0) |-> !cmdReady);

  p_erase_end_r9: assert property (@(posedge clk) disable iff (!rstN)
    (eraseLeft == CW'(1)) |=> cmdReady);

  p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(acc && (cmdCode == 3'd0 || cmdCode == 3'd1)) |=> $stable(addrOut));

endmodule

bind pgmAccessCtl pgmAccessCtl_chk #(
  .USER_WORDS  (USER_WORDS),
  .ERASE_CYCLES(ERASE_CYCLES),
  .DATA_W      (DATA_W)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .cmdValid (cmdValid),
  .cmdCode  (cmdCode),
  .cmdReady (cmdReady),
  .protectEn(protectEn),
  .rdData   (rdData),
  .addrOut  (addrOut),
  .cfgArmed (cfgArmed)
);

// File: tb/pgmAccessCtl_test.sv
`timescale 1ns/1ps
module pgmAccessCtl_test;

  localparam int          UW     = 16;
  localparam int          AW     = 5;
  localparam logic [11:0] BACKUP = 12'hC34;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdValid = 1'b0;
  logic [2:0]    cmdCode = 3'd0;
  logic [11:0]   cmdData = '0;
  logic          protectEn = 1'b0;
  logic          cmdReady;
  logic [11:0]   rdData;
  logic [AW-1:0] addrOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [11:0] expVal[$];
  string       expTag[$];

  always #10 clk = ~clk;

  pgmAccessCtl #(
    .USER_WORDS  (UW),
    .ID_WORDS    (4),
    .ERASE_CYCLES(16),
    .DATA_W      (12),
    .BACKUP_INIT (BACKUP)
  ) uut (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdCode  (cmdCode),
    .cmdData  (cmdData),
    .protectEn(protectEn),
    .cmdReady (cmdReady),
    .rdData   (rdData),
    .addrOut  (addrOut)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // driver: present a command, wait for acceptance, release
  task automatic doCmd(input logic [2:0] c, input logic [11:0] d);
    @(negedge clk);
    cmdValid = 1'b1; cmdCode = c; cmdData = d;
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic rd(input logic [11:0] exp, input string tag);
    expVal.push_back(exp);
    expTag.push_back(tag);
    doCmd(3'd3, '0);
  endtask

  task automatic incr();
    doCmd(3'd1, '0);
  endtask

  task automatic goTo(input int n);
    while (int'(addrOut) != n) incr();
  endtask

  // monitor: compare read results against the scoreboard queue
  initial begin
    forever begin
      @(posedge clk);
      if (rstN && cmdValid && cmdReady && cmdCode == 3'd3) begin
        @(negedge clk);
        if (expVal.size() == 0) begin
          check(1'b0, "unexpected read", int'(rdData), 0);
        end else begin
          logic [11:0] e;
          string t;
          e = expVal.pop_front();
          t = expTag.pop_front();
          check(rdData == e, t, int'(rdData), int'(e));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(addrOut == '0, "R1 reset counter", int'(addrOut), 0);
    check(cmdReady == 1'b1, "R1 reset ready", int'(cmdReady), 1);

    // configuration word while armed, ready timing
    doCmd(3'd2, 12'h3A5);
    check(cmdReady == 1'b0, "R9 ready low after load", int'(cmdReady), 0);
    @(negedge clk);
    check(cmdReady == 1'b1, "R9 ready back after one cycle", int'(cmdReady), 1);
    rd(12'h3A5, "R3 config word after entry");
    incr();
    check(addrOut == '0, "R3 first increment only disarms", int'(addrOut), 0);

    // user region and reset vector
    doCmd(3'd2, 12'hA01);
    rd(12'hA01, "R10 user word 0");
    goTo(UW - 1);
    doCmd(3'd2, 12'hC7E);
    rd(12'hC7E, "R10 reset vector written alone");
    incr();
    check(int'(addrOut) == UW, "R2 user end to config start", int'(addrOut), UW);

    // ID words
    for (int k = 0; k < 4; k++) begin
      doCmd(3'd2, 12'hF01 + 12'(k));
      rd(12'hF01 + 12'(k), "R4 ID word readback");
      incr();
    end
    rd(BACKUP, "R10 backup reset value");

    // reserved and unimplemented slots
    incr();
    doCmd(3'd2, 12'h123);
    rd(12'hFFF, "R5 reserved ignores load");
    goTo(UW + 8);
    doCmd(3'd2, 12'h456);
    rd(12'hFFF, "R5 unimplemented ignores load");
    goTo(2*UW - 1);
    doCmd(3'd2, 12'h555);
    rd(12'hFFF, "R3 config word unreachable after increment");
    incr();
    check(addrOut == '0, "R2 wrap to zero", int'(addrOut), 0);

    // protection
    protectEn = 1'b1;
    rd(12'h000, "R6 protected user read");
    goTo(UW);
    rd(12'hF01, "R4 ID readable under protection");

    // command during busy cycle is ignored
    @(negedge clk);
    cmdValid = 1'b1; cmdCode = 3'd1;
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    check(int'(addrOut) == UW + 1, "R11 busy increment ignored", int'(addrOut), UW + 1);

    doCmd(3'd0, '0);
    check(addrOut == '0, "R1 enter resets counter", int'(addrOut), 0);
    rd(12'h3A5, "R6 config word unaffected by protection");
    protectEn = 1'b0;

    // erase from user region
    doCmd(3'd4, '0);
    begin
      int lows = 0;
      while (!cmdReady && lows < 100) begin
        lows++;
        @(negedge clk);
      end
      check(lows == 16, "R9 erase busy length", lows, 16);
    end
    rd(12'hFFF, "R7 config word erased");
    incr();
    rd(12'hFFF, "R7 user word erased");
    goTo(UW);
    rd(12'hFFF, "R7 ID word erased");
    goTo(UW + 4);
    rd(BACKUP, "R7 backup kept");

    // erase from config region
    doCmd(3'd2, 12'h2B4);
    rd(12'h2B4, "R10 backup rewritten");
    doCmd(3'd4, '0);
    while (!cmdReady) @(negedge clk);
    rd(12'hFFF, "R8 backup erased");

    repeat (3) @(negedge clk);
    check(expVal.size() == 0, "scoreboard drained", expVal.size(), 0);
    summary();
  end

endmodule